// File: doc/BRIEF.md
# Gated Pulse Accumulator

This block is an 8-bit counter driven by a single input pin. In event mode it adds one to its count on each selected transition of the pin. In gated mode it counts a fixed internal time base, one step every 64 system clocks, for as long as the pin sits at its enabling level. When the pin is configured as an output, the value the chip drives onto it is looped back into the accumulator, so the block can count its own output.

A small register bus reaches three registers: control, count and status. The count can be read or written at any moment and keeps its value through reset. The status register holds two sticky flags: count wrap and selected edge. Writing a 1 to a flag bit clears that flag.

The pin passes through a two-flop synchronizer into a level-tracking state machine with three states. `LV_UNKNOWN` is entered on reset and holds no history. `LV_LOW` and `LV_HIGH` record the last synchronized level. The transitions are:
- UNKNOWN→LOW and UNKNOWN→HIGH: the first sample after reset. No edge is reported.
- LOW→HIGH: reports a rising edge.
- HIGH→LOW: reports a falling edge.
- LOW→LOW and HIGH→HIGH: hold, with no edge.

Top module: `pulse_accum`

## Requirements
- R1: The control register is at address 0. Bit 6 enables counting. Bit 5 selects the mode (0 = event, 1 = gated). Bit 4 is the select bit. All three bits reset to 0, write and read back as written, and every other bit reads 0.
- R2: In event mode with enable set, the count rises by exactly one on each falling pin edge when select=0, and on each rising pin edge when select=1. The other edge direction leaves the count unchanged.
- R3: In gated mode with enable set, the count rises by one every 64 clocks while the gate is open. With select=0 a low pin closes the gate. With select=1 a high pin closes the gate. While the gate is closed the count holds.
- R4: With enable clear, the count never changes, in either mode, except through a bus write.
- R5: The count register is at address 1. It can be read and written at any time, and reset leaves its value unchanged.
- R6: When `pin_dir_out` is 1, the accumulator sees `pin_out_val` in place of `pin_ext`.
- R7: When an increment takes the count from 0xFF to 0x00, the overflow flag (status register at address 2, bit 7) is set. The flag stays set until a write to address 2 with bit 7 = 1 clears it.
- R8: The edge flag (status bit 6) is set on every edge that the select bit chooses (falling for 0, rising for 1), whatever the mode or enable. It stays set until a write to address 2 with bit 6 = 1 clears it.
- R9: If a bus write to the count lands in the same cycle as an increment, the count takes the written value and no overflow is flagged.
- R10: An event-mode increment appears on the count output three clock edges after the pin changes: two synchronizer stages, then the count register.
- R11: Reads are combinational from the registers. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset (the count is not reset) |
| pin_ext | input | 1 | External level on the shared pin |
| pin_dir_out | input | 1 | 1 when the shared pin is driven as an output |
| pin_out_val | input | 1 | Value driven onto the pin when it is an output |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register address (0 control, 1 count, 2 status) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |

## Verification
Assertions check the following on every cycle:
- Rise and fall are never reported together, and a rise always follows a low sample.
- The prescaler tick never fires on two consecutive cycles.
- A disabled accumulator holds its count, and gated counting moves only on a tick.
- A bus write to the count always wins over an increment.
- A wrap from 0xFF always sets the overflow flag.

Only the directed scenarios can show the rest: the three-edge latency, the meaning of the select bit in each mode, the loopback of the output value, the rate of gated counting over many ticks, and a count that survives reset.

// File: rtl/pa_pkg.sv
package pa_pkg;

    localparam int CNT_W       = 8;
    localparam int ADDR_W      = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_STAT  = 2'd2;

    localparam int CTL_EN_BIT   = 6;
    localparam int CTL_MODE_BIT = 5;
    localparam int CTL_SEL_BIT  = 4;

    localparam int ST_OVF_BIT   = 7;
    localparam int ST_EDGE_BIT  = 6;

    typedef enum logic [1:0] {
        LV_UNKNOWN = 2'd0,
        LV_LOW     = 2'd1,
        LV_HIGH    = 2'd2
    } lvl_state_e;

endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pa_prescaler.sv
module pa_prescaler #(
    parameter int DIV_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign tick = &div_q;

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3
endmodule

// File: rtl/pa_level_fsm.sv
module pa_level_fsm
    import pa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    lvl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LV_UNKNOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_UNKNOWN: state_d = lvl ? LV_HIGH : LV_LOW;
            LV_LOW:     state_d = lvl ? LV_HIGH : LV_LOW;
            LV_HIGH:    state_d = lvl ? LV_HIGH : LV_LOW;
            default:    state_d = LV_UNKNOWN;
        endcase
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            LV_LOW:     rise = lvl;
            LV_HIGH:    fall = !lvl;
            default:    ;
        endcase
    end

    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall})); // R2
    AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (lvl && !$past(lvl))); // R2
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pa_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRESC_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_ext,
    input  logic              pin_dir_out,
    input  logic              pin_out_val,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic pin_seen, lvl_s, rise, fall, tick;
    logic en_q, mode_q, sel_q, ovf_q, edge_q;
    logic [CNT_W-1:0] count_q;
    logic wr_ctrl, wr_cnt, wr_stat;
    logic edge_hit, evt_inc, gate_open, gated_inc, inc;

    assign pin_seen = pin_dir_out ? pin_out_val : pin_ext;

    pa_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pin_seen),
        .q   (lvl_s)
    );

    pa_level_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl_s),
        .rise  (rise),
        .fall  (fall)
    );

    pa_prescaler #(.DIV_W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
    assign wr_cnt  = bus_wr && (bus_addr == ADR_COUNT);
    assign wr_stat = bus_wr && (bus_addr == ADR_STAT);

    assign edge_hit  = sel_q ? rise : fall;
    assign evt_inc   = en_q && !mode_q && edge_hit;
    assign gate_open = lvl_s ^ sel_q;
    assign gated_inc = en_q && mode_q && tick && gate_open;
    assign inc       = evt_inc || gated_inc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
            sel_q  <= 1'b0;
        end else if (wr_ctrl) begin
            en_q   <= bus_wdata[CTL_EN_BIT];
            mode_q <= bus_wdata[CTL_MODE_BIT];
            sel_q  <= bus_wdata[CTL_SEL_BIT];
        end
    end

    // count keeps its value across reset
    always_ff @(posedge clk) begin
        if (wr_cnt)   count_q <= bus_wdata;
        else if (inc) count_q <= count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            if (inc && !wr_cnt && (count_q == CNT_MAX)) ovf_q <= 1'b1;
            else if (wr_stat && bus_wdata[ST_OVF_BIT])  ovf_q <= 1'b0;
            if (edge_hit)                                edge_q <= 1'b1;
            else if (wr_stat && bus_wdata[ST_EDGE_BIT]) edge_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CTRL: begin
                bus_rdata[CTL_EN_BIT]   = en_q;
                bus_rdata[CTL_MODE_BIT] = mode_q;
                bus_rdata[CTL_SEL_BIT]  = sel_q;
            end
            ADR_COUNT: bus_rdata = count_q;
            ADR_STAT: begin
                bus_rdata[ST_OVF_BIT]  = ovf_q;
                bus_rdata[ST_EDGE_BIT] = edge_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (count_q == $past(bus_wdata))); // R9
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !wr_cnt) |=> $stable(count_q)); // R4
    AST_GATED_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mode_q && !wr_cnt && !tick) |=> $stable(count_q)); // R3
    AST_NO_LOST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_cnt && count_q == CNT_MAX) |=> (ovf_q && count_q == '0)); // R7
endmodule

// File: tb/pulse_accum_test.sv
module pulse_accum_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_ext = 1'b0;
    logic       pin_dir_out = 1'b0;
    logic       pin_out_val = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rd, base;

    always #2 clk = ~clk;

    pulse_accum uut (
        .clk(clk), .rst_n(rst_n), .pin_ext(pin_ext), .pin_dir_out(pin_dir_out),
        .pin_out_val(pin_out_val), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input logic [7:0] act, input int lo, input int hi);
        n_chk++;
        if (int'(act) < lo || int'(act) > hi) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    // called at a negedge, returns at a negedge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle(input logic v);
        pin_ext = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state;
        rdreg(2'd0, rd); chk("R1 ctrl reset", rd, 8'h00);
        rdreg(2'd3, rd); chk("R11 addr3 reads zero", rd, 8'h00);
        wr(2'd0, 8'hFF);
        rdreg(2'd0, rd); chk("R1 ctrl readback", rd, 8'h70);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_event_edges;
        settle(1'b0);
        wr(2'd0, 8'h50);            // enable, event, rising
        wr(2'd1, 8'h10);
        settle(1'b1);
        rdreg(2'd1, rd); chk("R2 rising counted", rd, 8'h11);
        settle(1'b0);
        rdreg(2'd1, rd); chk("R2 falling ignored with sel=1", rd, 8'h11);
        wr(2'd0, 8'h40);            // falling
        settle(1'b1);
        rdreg(2'd1, rd); chk("R2 rising ignored with sel=0", rd, 8'h11);
        settle(1'b0);
        rdreg(2'd1, rd); chk("R2 falling counted", rd, 8'h12);
        for (int i = 0; i < 5; i++) begin settle(1'b1); settle(1'b0); end
        rdreg(2'd1, rd); chk("R2 five pulses", rd, 8'h17);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_latency;
        settle(1'b0);
        wr(2'd0, 8'h50);
        wr(2'd1, 8'h20);
        pin_ext = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rdreg(2'd1, rd); chk("R10 not yet after two edges", rd, 8'h20);
        @(posedge clk); @(negedge clk);
        rdreg(2'd1, rd); chk("R10 counted on third edge", rd, 8'h21);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_disabled;
        settle(1'b0);
        wr(2'd1, 8'h33);
        wr(2'd0, 8'h10);            // disabled, event, rising
        for (int i = 0; i < 3; i++) begin settle(1'b1); settle(1'b0); end
        rdreg(2'd1, rd); chk("R4 disabled event", rd, 8'h33);
        wr(2'd0, 8'h20);            // disabled, gated
        settle(1'b1);
        repeat (200) @(negedge clk);
        rdreg(2'd1, rd); chk("R4 disabled gated", rd, 8'h33);
        wr(2'd0, 8'h00);
        settle(1'b0);
    endtask

    task automatic t_gated;
        settle(1'b1);
        wr(2'd0, 8'h60);            // enable, gated, low stops
        wr(2'd1, 8'h00);
        repeat (640) @(negedge clk);
        rdreg(2'd1, rd); chk_rng("R3 gate open high rate", rd, 9, 11);
        settle(1'b0);
        rdreg(2'd1, base);
        repeat (200) @(negedge clk);
        rdreg(2'd1, rd); chk("R3 low stops with sel=0", rd, base);
        wr(2'd0, 8'h70);            // high stops
        wr(2'd1, 8'h00);
        repeat (640) @(negedge clk);
        rdreg(2'd1, rd); chk_rng("R3 low opens with sel=1", rd, 9, 11);
        settle(1'b1);
        rdreg(2'd1, base);
        repeat (200) @(negedge clk);
        rdreg(2'd1, rd); chk("R3 high stops with sel=1", rd, base);
        wr(2'd0, 8'h00);
        settle(1'b0);
    endtask

    task automatic t_loopback;
        settle(1'b0);
        pin_out_val = 1'b0;
        pin_dir_out = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h50);
        wr(2'd1, 8'h40);
        for (int i = 0; i < 3; i++) begin
            pin_out_val = 1'b1; repeat (4) @(negedge clk);
            pin_out_val = 1'b0; repeat (4) @(negedge clk);
        end
        rdreg(2'd1, rd); chk("R6 counts own output", rd, 8'h43);
        settle(1'b1); settle(1'b0);
        rdreg(2'd1, rd); chk("R6 external ignored when output", rd, 8'h43);
        pin_dir_out = 1'b0;
        wr(2'd0, 8'h00);
        settle(1'b0);
    endtask

    task automatic t_flags;
        settle(1'b0);
        wr(2'd0, 8'h50);
        wr(2'd2, 8'hC0);
        wr(2'd1, 8'hFF);
        settle(1'b1);
        rdreg(2'd1, rd); chk("R7 wrap to zero", rd, 8'h00);
        rdreg(2'd2, rd); chk("R7 R8 flags set", rd, 8'hC0);
        wr(2'd2, 8'h80);
        rdreg(2'd2, rd); chk("R7 overflow cleared alone", rd, 8'h40);
        wr(2'd2, 8'h40);
        rdreg(2'd2, rd); chk("R8 edge cleared", rd, 8'h00);
        wr(2'd0, 8'h30);            // disabled, gated, rising edge select
        settle(1'b0); settle(1'b1);
        rdreg(2'd2, rd); chk("R8 edge flag while disabled", rd, 8'h40);
        wr(2'd2, 8'h40);
        wr(2'd0, 8'h00);
        settle(1'b0);
    endtask

    task automatic t_write_wins;
        settle(1'b0);
        wr(2'd0, 8'h50);
        wr(2'd2, 8'hC0);
        wr(2'd1, 8'hFF);
        pin_ext = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(2'd1, 8'h33);            // lands with the increment
        rdreg(2'd1, rd); chk("R9 written value wins", rd, 8'h33);
        rdreg(2'd2, rd); chk("R9 no overflow on collision", rd, 8'h40);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_reset_keeps;
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'h70);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rdreg(2'd1, rd); chk("R5 count kept through reset", rd, 8'h5A);
        rdreg(2'd0, rd); chk("R1 ctrl cleared by reset", rd, 8'h00);
        rdreg(2'd2, rd); chk("R7 flags cleared by reset", rd, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_event_edges();
        t_latency();
        t_disabled();
        t_gated();
        t_loopback();
        t_flags();
        t_write_wins();
        t_reset_keeps();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule